// File: doc/BRIEF.md
# Debug System-Bus Access Master

This block lets a debugger reach system memory without involving a processor. The debugger sees five 32-bit words through a simple register port: a control/status word, the low and high halves of a 64-bit target address, and the low and high halves of a 64-bit data register. Certain accesses to these words start a single read or write on a request/ready/error memory interface. The transfer carries an access size of 8, 16, 32 or 64 bits.

Only two words have bus side effects. Writing the low data word starts a write. Writing the low address word starts a read when the read-on-address mode is enabled. Reading the low data word returns the held data and, when the read-on-data mode is enabled, then starts a read. After each successful transfer, an optional auto-increment advances the address by the access size.

Error reporting is sticky. A failed start (unsupported size, misaligned address) or a failed transfer (bus error response, timeout) records an error code. Touching an address or data word while a transfer is in flight sets a separate busy-error flag. While either indication is set, no new transfer starts, until the debugger clears it by writing ones.

Top module: `dbg_sysbus_master`

## Requirements
- R1: After reset the control word reads 0x0000_0020, and every other word reads 0 with `bus_req` low. The control word holds the access size in bits 6:4 (reset 2), auto-increment in bit 0, read-on-address in bit 1, read-on-data in bit 2, the error code in bits 10:8, busy-error in bit 12 and busy in bit 13 (read-only).
- R2: The access size encodes 0=8, 1=16, 2=32 and 3=64 bits. A start with any larger size code performs no transfer and sets the error code to 4.
- R3: A start whose address is not a multiple of the access size in bytes performs no transfer and sets the error code to 3.
- R4: Writing the low data word (select 3) while idle and error-free raises `bus_req` with `bus_we`=1 from the next cycle. `bus_addr`, `bus_size` and `bus_wdata` show the address, size and full data register, and `bus_req` stays high until the cycle in which `bus_ready` is seen.
- R5: Writing the low address word (select 1) with read-on-address set starts a read at the newly written address. With the mode clear it starts nothing. The high address word is at select 2.
- R6: Reading the low data word returns the data held before the access. With read-on-data set, it then starts a read at the current address.
- R7: A completed read loads the returned bits of the access size into the data register, zero-extended to 64 bits. The low data word is at select 3 and the high data word at select 4.
- R8: With auto-increment set, the address grows by the access size in bytes after each successful transfer, and not after a failed one.
- R9: A ready with `bus_err` high sets error code 2. A transfer that sees no ready for TIMEOUT cycles drops `bus_req` and sets error code 1.
- R10: A nonzero error code stays until cleared by writing ones to bits 10:8 of the control word. While it is nonzero, no transfer starts, but data words still take written values.
- R11: A write to either address word, or any access to either data word, made while busy sets busy-error (bit 12) and has no other effect. Busy-error clears only by writing a one to bit 12, and while set it blocks starts.
- R12: Writing or reading the high data word and writing the high address word never start a transfer. They only store or return the word.
- R13: Control-word writes made while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe, one access per cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 3 | Word select: 0 control, 1 address low, 2 address high, 3 data low, 4 data high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected word (combinational) |
| bus_req | output | 1 | Transfer request, held until ready or timeout |
| bus_we | output | 1 | 1 = write transfer |
| bus_addr | output | 64 | Transfer byte address |
| bus_size | output | 3 | Access size code (bytes = 1 << code) |
| bus_wdata | output | 64 | Write data |
| bus_ready | input | 1 | Transfer completion |
| bus_err | input | 1 | Error response, valid with bus_ready |
| bus_rdata | input | 64 | Read data, valid with bus_ready |

## Verification
The hardest situation to reach from the ports is a register access that collides with an in-flight transfer. The collision must then be shown to do nothing except set busy-error: the address is not overwritten, and the following start is refused. The bench gets there by giving its bus responder a long, programmable latency, and by issuing address and control writes in the cycles right after a data-word write has raised `bus_req`. A responder mode that never answers drives the timeout path, and the bench counts the exact number of cycles `bus_req` stays high.

// File: rtl/dbm_pkg.sv
package dbm_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL    = 3'd0,
    SEL_ADDR_LO = 3'd1,
    SEL_ADDR_HI = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } dbm_sel_e;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_TIMEOUT = 3'd1,
    ERR_BADADDR = 3'd2,
    ERR_ALIGN   = 3'd3,
    ERR_SIZE    = 3'd4,
    ERR_OTHER   = 3'd7
  } dbm_err_e;

  // control word bit positions
  localparam int CB_AUTOINC  = 0;
  localparam int CB_RD_ADDR  = 1;
  localparam int CB_RD_DATA  = 2;
  localparam int CB_SIZE_LO  = 4;
  localparam int CB_ERR_LO   = 8;
  localparam int CB_BUSYERR  = 12;
  localparam int CB_BUSY     = 13;

  localparam logic [2:0] SIZE_RESET = 3'd2;

endpackage

// File: rtl/dbm_szdec.sv
module dbm_szdec #(
  parameter int AW = 64,
  parameter int DW = 64
) (
  input  logic [2:0]               size_i,
  output logic                     legal_o,
  output logic [AW-1:0]            step_o,
  output logic [$clog2(DW/8)-1:0]  lomask_o,
  output logic [DW-1:0]            rmask_o
);
  localparam int NBYTES  = DW / 8;
  localparam int MAXCODE = $clog2(NBYTES);

  assign legal_o = (32'(size_i) <= MAXCODE);
  assign step_o  = AW'(1) << size_i;

  // address bits that must be zero for the selected size
  for (genvar i = 0; i < MAXCODE; i++) begin : g_lomask
    assign lomask_o[i] = (32'(size_i) > i);
  end

  // byte lanes covered by the selected size
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign rmask_o[b*8 +: 8] = {8{(b < (32'd1 << size_i))}};
  end

endmodule

// File: rtl/dbm_xfer.sv
module dbm_xfer #(
  parameter int TIMEOUT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic start_we_i,
  input  logic bus_ready_i,
  input  logic bus_err_i,
  output logic busy_o,
  output logic we_o,
  output logic done_ok_o,
  output logic done_buserr_o,
  output logic done_timeout_o
);
  localparam int CW = $clog2(TIMEOUT + 1);

  logic          busy_q, busy_n;
  logic          we_q, we_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          ready_hit, expired;

  assign ready_hit      = busy_q & bus_ready_i;
  assign expired        = busy_q & ~bus_ready_i & (cnt_q == CW'(TIMEOUT - 1));
  assign done_ok_o      = ready_hit & ~bus_err_i;
  assign done_buserr_o  = ready_hit & bus_err_i;
  assign done_timeout_o = expired;
  assign busy_o         = busy_q;
  assign we_o           = we_q;

  always_comb begin
    busy_n = busy_q;
    we_n   = we_q;
    cnt_n  = cnt_q;
    if (start_i) begin
      busy_n = 1'b1;
      we_n   = start_we_i;
      cnt_n  = '0;
    end else if (busy_q) begin
      if (ready_hit || expired) busy_n = 1'b0;
      else                      cnt_n  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      if (start_i) we_q <= we_n;
      if (start_i || busy_q) cnt_q <= cnt_n;
    end
  end

  // R4: request held until ready or expiry
  p_req_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !bus_ready_i && !done_timeout_o) |=> busy_q);
  // R9: expiry drops the request
  p_tmo_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_timeout_o |=> !busy_q);
  // R11: a start is never issued while a transfer is in flight
  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

endmodule

// File: rtl/dbm_regs.sv
module dbm_regs
  import dbm_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_valid_i,
  input  logic          reg_write_i,
  input  logic [2:0]    reg_sel_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          busy_i,
  input  logic          xfer_we_i,
  input  logic          done_ok_i,
  input  logic          done_buserr_i,
  input  logic          done_timeout_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          size_legal_i,
  input  logic [AW-1:0] step_i,
  input  logic [LW-1:0] lomask_i,
  input  logic [DW-1:0] rmask_i,
  output logic          start_o,
  output logic          start_we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [2:0]    size_o
);
  logic          ai_q, roa_q, rod_q, berr_q;
  logic [2:0]    size_q, err_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic          ai_n, roa_n, rod_n, berr_n;
  logic [2:0]    size_n, err_n;
  logic [AW-1:0] addr_n, addr_cand;
  logic [DW-1:0] data_n;
  logic          addr_en, data_en;

  logic hit_ctrl, hit_alo, hit_ahi, hit_dlo, hit_dhi;
  logic idle_acc, idle_wr, touch_busy, blocked;
  logic want_rd, want_wr, try_go, misal;

  assign hit_ctrl = (reg_sel_i == SEL_CTRL);
  assign hit_alo  = (reg_sel_i == SEL_ADDR_LO);
  assign hit_ahi  = (reg_sel_i == SEL_ADDR_HI);
  assign hit_dlo  = (reg_sel_i == SEL_DATA_LO);
  assign hit_dhi  = (reg_sel_i == SEL_DATA_HI);

  assign idle_acc   = reg_valid_i & ~busy_i;
  assign idle_wr    = idle_acc & reg_write_i;
  assign touch_busy = busy_i & reg_valid_i &
                      ((reg_write_i & (hit_alo | hit_ahi)) | hit_dlo | hit_dhi);
  assign blocked    = (err_q != ERR_NONE) | berr_q;

  always_comb begin
    addr_cand = addr_q;
    if (idle_wr && hit_alo) addr_cand[31:0]    = reg_wdata_i;
    if (idle_wr && hit_ahi) addr_cand[AW-1:32] = reg_wdata_i[AW-33:0];
  end

  assign want_rd = idle_acc & ((reg_write_i & hit_alo & roa_q) |
                               (~reg_write_i & hit_dlo & rod_q));
  assign want_wr = idle_wr & hit_dlo;
  assign try_go  = (want_rd | want_wr) & ~blocked;
  assign misal   = |(addr_cand[LW-1:0] & lomask_i);

  assign start_o    = try_go & size_legal_i & ~misal;
  assign start_we_o = want_wr;

  always_comb begin
    ai_n   = ai_q;
    roa_n  = roa_q;
    rod_n  = rod_q;
    size_n = size_q;
    err_n  = err_q;
    berr_n = berr_q;
    addr_n = addr_cand;
    data_n = data_q;
    if (idle_wr && hit_ctrl) begin
      ai_n   = reg_wdata_i[CB_AUTOINC];
      roa_n  = reg_wdata_i[CB_RD_ADDR];
      rod_n  = reg_wdata_i[CB_RD_DATA];
      size_n = reg_wdata_i[CB_SIZE_LO +: 3];
      err_n  = err_q & ~reg_wdata_i[CB_ERR_LO +: 3];
      berr_n = berr_q & ~reg_wdata_i[CB_BUSYERR];
    end
    if (idle_wr && hit_dlo) data_n[31:0]    = reg_wdata_i;
    if (idle_wr && hit_dhi) data_n[DW-1:32] = reg_wdata_i[DW-33:0];
    if (touch_busy) berr_n = 1'b1;
    if (try_go && !size_legal_i) err_n = ERR_SIZE;
    else if (try_go && misal)    err_n = ERR_ALIGN;
    if (done_ok_i) begin
      if (!xfer_we_i) data_n = bus_rdata_i & rmask_i;
      if (ai_q)       addr_n = addr_q + step_i;
    end
    if (done_buserr_i)  err_n = ERR_BADADDR;
    if (done_timeout_i) err_n = ERR_TIMEOUT;
  end

  assign addr_en = (idle_wr & (hit_alo | hit_ahi)) | (done_ok_i & ai_q);
  assign data_en = (idle_wr & (hit_dlo | hit_dhi)) | (done_ok_i & ~xfer_we_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ai_q   <= 1'b0;
      roa_q  <= 1'b0;
      rod_q  <= 1'b0;
      size_q <= SIZE_RESET;
      err_q  <= ERR_NONE;
      berr_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      ai_q   <= ai_n;
      roa_q  <= roa_n;
      rod_q  <= rod_n;
      size_q <= size_n;
      err_q  <= err_n;
      berr_q <= berr_n;
      if (addr_en) addr_q <= addr_n;
      if (data_en) data_q <= data_n;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_CTRL: begin
        reg_rdata_o[CB_AUTOINC]      = ai_q;
        reg_rdata_o[CB_RD_ADDR]      = roa_q;
        reg_rdata_o[CB_RD_DATA]      = rod_q;
        reg_rdata_o[CB_SIZE_LO +: 3] = size_q;
        reg_rdata_o[CB_ERR_LO +: 3]  = err_q;
        reg_rdata_o[CB_BUSYERR]      = berr_q;
        reg_rdata_o[CB_BUSY]         = busy_i;
      end
      SEL_ADDR_LO: reg_rdata_o = addr_q[31:0];
      SEL_ADDR_HI: reg_rdata_o = 32'(addr_q[AW-1:32]);
      SEL_DATA_LO: reg_rdata_o = data_q[31:0];
      SEL_DATA_HI: reg_rdata_o = 32'(data_q[DW-1:32]);
      default:     reg_rdata_o = '0;
    endcase
  end

  assign addr_o = addr_q;
  assign data_o = data_q;
  assign size_o = size_q;

  // R4: a start is answered by the transfer engine next cycle
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> busy_i);
  // R10: a recorded error survives until a control write clears it
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != ERR_NONE && !(reg_valid_i && reg_write_i && hit_ctrl)) |=> $stable(err_q));
  // R11: address and data frozen while a transfer runs
  p_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !done_ok_i) |=> ($stable(addr_q) && $stable(data_q)));
  // R11: colliding address write raises busy-error
  p_berr_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && reg_valid_i && reg_write_i && hit_alo) |=> berr_q);

endmodule

// File: rtl/dbg_sysbus_master.sv
module dbg_sysbus_master #(
  parameter int AW      = 64,
  parameter int DW      = 64,
  parameter int TIMEOUT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_valid,
  input  logic          reg_write,
  input  logic [2:0]    reg_sel,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic [DW-1:0] bus_rdata
);
  localparam int LW = $clog2(DW / 8);

  logic          size_legal;
  logic [AW-1:0] step;
  logic [LW-1:0] lomask;
  logic [DW-1:0] rmask;
  logic          start, start_we, busy, xfer_we;
  logic          done_ok, done_buserr, done_timeout;

  dbm_szdec #(.AW(AW), .DW(DW)) u_szdec (
    .size_i   (bus_size),
    .legal_o  (size_legal),
    .step_o   (step),
    .lomask_o (lomask),
    .rmask_o  (rmask)
  );

  dbm_xfer #(.TIMEOUT(TIMEOUT)) u_xfer (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start),
    .start_we_i     (start_we),
    .bus_ready_i    (bus_ready),
    .bus_err_i      (bus_err),
    .busy_o         (busy),
    .we_o           (xfer_we),
    .done_ok_o      (done_ok),
    .done_buserr_o  (done_buserr),
    .done_timeout_o (done_timeout)
  );

  dbm_regs #(.AW(AW), .DW(DW), .LW(LW)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_valid_i    (reg_valid),
    .reg_write_i    (reg_write),
    .reg_sel_i      (reg_sel),
    .reg_wdata_i    (reg_wdata),
    .reg_rdata_o    (reg_rdata),
    .busy_i         (busy),
    .xfer_we_i      (xfer_we),
    .done_ok_i      (done_ok),
    .done_buserr_i  (done_buserr),
    .done_timeout_i (done_timeout),
    .bus_rdata_i    (bus_rdata),
    .size_legal_i   (size_legal),
    .step_i         (step),
    .lomask_i       (lomask),
    .rmask_i        (rmask),
    .start_o        (start),
    .start_we_o     (start_we),
    .addr_o         (bus_addr),
    .data_o         (bus_wdata),
    .size_o         (bus_size)
  );

  assign bus_req = busy;
  assign bus_we  = xfer_we;

  // R2: only supported sizes ever reach the bus
  p_size_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (32'(bus_size) <= LW));
  // R3: every issued address is aligned to its size
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ((32'(bus_addr[LW-1:0]) % (32'd1 << bus_size)) == 0));
  // R4: transfer attributes hold while waiting for ready
  p_attr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (!bus_req || ($stable(bus_addr) && $stable(bus_we))));

endmodule

// File: tb/dbg_sysbus_master_test.sv
module dbg_sysbus_master_test;
  localparam int TMO = 8;

  logic        clk, rst_n;
  logic        reg_valid, reg_write;
  logic [2:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        bus_req, bus_we, bus_ready, bus_err;
  logic [63:0] bus_addr, bus_wdata, bus_rdata;
  logic [2:0]  bus_size;

  dbg_sysbus_master #(.AW(64), .DW(64), .TIMEOUT(TMO)) uut (
    .clk(clk), .rst_n(rst_n),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- bus responder ----------------
  int  rsp_lat = 2;
  bit  rsp_err = 0;
  bit  rsp_hang = 0;
  int  rsp_cnt = 0;

  function automatic logic [63:0] pattern(input logic [63:0] a);
    return {~a[31:0], a[31:0] ^ 32'h5A5A_C3C3};
  endfunction

  always @(negedge clk) begin
    bus_ready <= 1'b0;
    bus_err   <= 1'b0;
    if (bus_req && !rsp_hang && !bus_ready) begin
      if (rsp_cnt >= rsp_lat) begin
        bus_ready <= 1'b1;
        bus_err   <= rsp_err;
        bus_rdata <= pattern(bus_addr);
        rsp_cnt   = 0;
      end else rsp_cnt++;
    end else if (!bus_req) rsp_cnt = 0;
  end

  // ---------------- behavioural reference model ----------------
  bit          m_ai, m_roa, m_rod, m_berr, m_busy, m_we;
  int          m_size, m_err, m_wait;
  logic [63:0] m_addr, m_data;

  function automatic logic [63:0] lane_mask(input int s);
    if (s >= 3) return '1;
    return (64'd1 << (8 * (1 << s))) - 64'd1;
  endfunction

  task automatic m_try(input bit wr);
    if (m_err == 0 && !m_berr) begin
      if (m_size > 3) m_err = 4;
      else if ((m_addr % (64'd1 << m_size)) != 0) m_err = 3;
      else begin
        m_busy = 1; m_we = wr; m_wait = 0;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ai = 0; m_roa = 0; m_rod = 0; m_berr = 0; m_busy = 0; m_we = 0;
      m_size = 2; m_err = 0; m_wait = 0; m_addr = '0; m_data = '0;
    end else begin
      bit ob;
      ob = m_busy;
      if (ob) begin
        if (bus_ready) begin
          m_busy = 0;
          if (bus_err) m_err = 2;
          else begin
            if (!m_we) m_data = bus_rdata & lane_mask(m_size);
            if (m_ai) m_addr = m_addr + (64'd1 << m_size);
          end
        end else if (m_wait == TMO - 1) begin
          m_busy = 0; m_err = 1;
        end else m_wait++;
      end
      if (reg_valid) begin
        if (ob) begin
          if ((reg_write && (reg_sel == 3'd1 || reg_sel == 3'd2)) || reg_sel == 3'd3 || reg_sel == 3'd4)
            m_berr = 1;
        end else if (reg_write) begin
          case (reg_sel)
            3'd0: begin
              m_ai = reg_wdata[0]; m_roa = reg_wdata[1]; m_rod = reg_wdata[2];
              m_size = int'(reg_wdata[6:4]);
              m_err = m_err & ~int'(reg_wdata[10:8]);
              if (reg_wdata[12]) m_berr = 0;
            end
            3'd1: begin m_addr[31:0] = reg_wdata; if (m_roa) m_try(0); end
            3'd2: m_addr[63:32] = reg_wdata;
            3'd3: begin m_data[31:0] = reg_wdata; m_try(1); end
            3'd4: m_data[63:32] = reg_wdata;
            default: ;
          endcase
        end else if (reg_sel == 3'd3 && m_rod) m_try(0);
      end
    end
  end

  // every-clock comparison of the bus side against the model (R4)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(bus_req == m_busy, "R4 model bus_req", 64'(bus_req), 64'(m_busy));
      if (m_busy && bus_req) begin
        chk(bus_addr == m_addr, "R4 model bus_addr", bus_addr, m_addr);
        chk(bus_we == m_we, "R4 model bus_we", 64'(bus_we), 64'(m_we));
        chk(32'(bus_size) == m_size, "R2 model bus_size", 64'(bus_size), 64'(m_size));
        if (m_we) chk(bus_wdata == m_data, "R4 model bus_wdata", bus_wdata, m_data);
      end
    end
  end

  // ---------------- driver tasks ----------------
  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_valid = 1; reg_write = 0; reg_sel = sel;
    #1 chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    @(negedge clk);
    reg_valid = 0;
  endtask

  task automatic peek(input logic [2:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_valid = 0; reg_sel = sel;
    #1 chk(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wait_idle();
    while (bus_req) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    reg_valid = 0; reg_write = 0; reg_sel = 0; reg_wdata = 0;
    bus_ready = 0; bus_err = 0; bus_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    peek(3'd0, 32'h0000_0020, "R1 ctrl reset");
    peek(3'd3, 32'h0, "R1 data reset");
    chk(bus_req == 0, "R1 bus_req reset", 64'(bus_req), 0);

    // R5 plain address writes start nothing; R12 high word stores
    wr(3'd1, 32'h0000_0100);
    chk(bus_req == 0, "R5 no read without mode", 64'(bus_req), 0);
    wr(3'd2, 32'h0000_0001);
    chk(bus_req == 0, "R12 addr_hi no start", 64'(bus_req), 0);
    peek(3'd2, 32'h1, "R12 addr_hi stored");

    // R4 write transfer
    wr(3'd4, 32'hCAFE_0000);
    wr(3'd3, 32'h1234_5678);
    chk(bus_req && bus_we, "R4 write started", {bus_req, bus_we}, 2'b11);
    chk(bus_wdata == 64'hCAFE_0000_1234_5678, "R4 write data", bus_wdata, 64'hCAFE_0000_1234_5678);
    peek(3'd0, 32'h0000_2020, "R4 busy bit");
    wait_idle();
    peek(3'd0, 32'h0000_0020, "R4 done clean");

    // R5 read on address, R7 zero extend, R8 increment
    wr(3'd0, 32'h23);
    wr(3'd1, 32'h0000_0200);
    chk(bus_req && !bus_we && bus_addr == 64'h1_0000_0200, "R5 read at new address", bus_addr, 64'h1_0000_0200);
    wait_idle();
    peek(3'd3, 32'h5A5A_C1C3, "R7 word read low");
    peek(3'd4, 32'h0, "R7 word read zero-extended");
    peek(3'd1, 32'h0000_0204, "R8 increment by 4");

    // byte read
    wr(3'd0, 32'h03);
    wr(3'd1, 32'h0000_0301);
    wait_idle();
    peek(3'd3, 32'h0000_00C2, "R7 byte read masked");
    peek(3'd1, 32'h0000_0302, "R8 increment by 1");

    // R6 read on data, 64-bit
    wr(3'd0, 32'h35);
    wr(3'd1, 32'h0000_0400);
    chk(bus_req == 0, "R5 mode off no read", 64'(bus_req), 0);
    rd(3'd3, 32'h0000_00C2, "R6 returns old data");
    chk(bus_req && !bus_we, "R6 read started", 64'(bus_req), 1);
    wait_idle();
    peek(3'd3, 32'h5A5A_C7C3, "R6 new data low");
    peek(3'd4, 32'hFFFF_FBFF, "R6 new data high");
    peek(3'd1, 32'h0000_0408, "R8 increment by 8");

    // R11 collision while busy
    rsp_lat = 6;
    wr(3'd3, 32'h1);
    wr(3'd1, 32'h0000_0999);
    wait_idle();
    peek(3'd1, 32'h0000_0410, "R11 colliding addr write ignored");
    peek(3'd0, 32'h0000_1035, "R11 busy-error set");
    wr(3'd3, 32'h2);
    chk(bus_req == 0, "R11 busy-error blocks start", 64'(bus_req), 0);
    peek(3'd3, 32'h2, "R10 data still stored when blocked");
    wr(3'd0, 32'h1035);
    peek(3'd0, 32'h0000_0035, "R11 busy-error cleared");

    // R13 control write while busy
    wr(3'd3, 32'h3);
    wr(3'd0, 32'h20);
    wait_idle();
    peek(3'd0, 32'h0000_0035, "R13 ctrl write ignored while busy");
    peek(3'd1, 32'h0000_0418, "R8 increment after write");

    // R3 misaligned
    wr(3'd1, 32'h0000_041C);
    wr(3'd3, 32'h4);
    chk(bus_req == 0, "R3 no transfer misaligned", 64'(bus_req), 0);
    peek(3'd0, 32'h0000_0335, "R3 align error");
    wr(3'd0, 32'h335);
    peek(3'd0, 32'h0000_0035, "R10 align error cleared");

    // R2 unsupported size
    wr(3'd0, 32'h55);
    wr(3'd3, 32'h5);
    chk(bus_req == 0, "R2 no transfer bad size", 64'(bus_req), 0);
    peek(3'd0, 32'h0000_0455, "R2 size error");
    wr(3'd0, 32'h725);
    peek(3'd0, 32'h0000_0025, "R10 size error cleared");

    // R9 bus error
    rsp_lat = 1; rsp_err = 1;
    wr(3'd1, 32'h0000_0500);
    wr(3'd3, 32'h6);
    wait_idle();
    peek(3'd0, 32'h0000_0225, "R9 bad address error");
    peek(3'd1, 32'h0000_0500, "R8 no increment on failure");
    wr(3'd3, 32'h7);
    chk(bus_req == 0, "R10 error blocks start", 64'(bus_req), 0);
    peek(3'd0, 32'h0000_0225, "R10 error sticky");
    wr(3'd0, 32'h225);
    rsp_err = 0;

    // R9 timeout
    rsp_hang = 1;
    wr(3'd3, 32'h77);
    begin
      int n = 0;
      while (bus_req) begin n++; @(negedge clk); end
      chk(n == TMO, "R9 timeout length", 64'(n), 64'(TMO));
    end
    peek(3'd0, 32'h0000_0125, "R9 timeout error");
    wr(3'd0, 32'h125);
    rsp_hang = 0;

    // R12 upper data word has no side effects
    wr(3'd4, 32'h0000_AAAA);
    chk(bus_req == 0, "R12 data_hi write no start", 64'(bus_req), 0);
    rd(3'd4, 32'h0000_AAAA, "R12 data_hi read");
    chk(bus_req == 0, "R12 data_hi read no start", 64'(bus_req), 0);

    // R6 / R7 word read on data read clears upper bits
    rsp_lat = 2;
    rd(3'd3, 32'h0000_0077, "R6 returns held data");
    wait_idle();
    peek(3'd3, 32'h5A5A_C6C3, "R7 read low");
    peek(3'd4, 32'h0, "R7 upper cleared");
    peek(3'd1, 32'h0000_0504, "R8 increment after read");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule